// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a byte-oriented two-wire serial (I2C) target that lets a bus controller read and write the small bank of configuration registers of a regulator controller. Each transfer moves exactly one byte. A write is START, device address with the write bit, register pointer, data byte, STOP. A read is START, device address with the write bit, register pointer, repeated START, device address with the read bit, one data byte returned by the target, NACK from the controller, STOP. SDA is never driven high. The target only pulls the line low, through an output-enable, and it changes that enable only while SCL is low.

The device address is formed from two parts. One is a writable 8-bit base register. The other is a 2-bit offset taken from a strap input in the first clock cycle after reset. The target stays silent on the bus until the offset has been captured and the external register-load step signals completion on `init_done`. The configuration fields leave the block as plain level outputs. There is no streaming path, so no valid/ready handshake and no back-pressure exists: the bus protocol's own ACK is the only flow control.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset the registers hold these defaults: base address 0x10 = 0x08, 0x12 = 0x00, 0x13 = 0x78, 0x14 = 0x01, 0x15 = 0x02, 0x17 = 0x03, 0x18 = 0x02, 0x19 = 0x03, 0x1A = 0x00 and 0x1C = 0x00. The ports therefore show vout_code = 0x078, pg_mode = 1, oc_sel = 2, ov_sel = 3, pg_thr = 2 and ot_sel = 3.
- R2: The target acknowledges an address byte only when its upper 7 bits equal (base[6:0] + offset) mod 128. Any other address gets no ACK, and the rest of that transfer is ignored.
- R3: The offset is taken from `strap_ofs` once, in the first cycle after reset. Later changes on `strap_ofs` do not move the address.
- R4: While `init_done` is low the target acknowledges nothing and performs no register write.
- R5: A write changes the addressed register. The outputs are decoded from these fields: vout_code = {0x12 bit0, 0x13[7:0]}; 0x14 bit3 = ss_rate, bit2 = soft_stop_en, bit0 = pg_mode; oc_sel = 0x15[2:0]; ov_sel = 0x17[1:0]; pg_thr = 0x18[1:0]; ot_sel = 0x19[1:0]; bus_vsel = 0x1A bit1; soft_dis = 0x1C bit3.
- R6: A read returns the addressed register, most significant bit first, using the pointer set in the write phase before the repeated START.
- R7: A write to an unmapped pointer (any pointer outside 0x10, 0x12 to 0x15, 0x17 to 0x1A and 0x1C) is acknowledged and has no effect. A read of an unmapped pointer returns 0x00.
- R8: Bits outside a register's field are not stored and read back as 0. The field masks are 0x10:FF, 0x12:01, 0x13:FF, 0x14:0D, 0x15:07, 0x17:03, 0x18:03, 0x19:03, 0x1A:02 and 0x1C:08.
- R9: A write to the base register at 0x10 changes the responding address from the next transfer on. Base bit 7 plays no part in address matching.
- R10: `sda_oe` changes only while SCL is low. It is released after each ACK bit and data byte the target sends, and after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_ofs | input | OFS_W | Address offset strap, sampled once after reset |
| init_done | input | 1 | Register load and initialization finished |
| vout_code | output | 9 | Output voltage code |
| ss_rate | output | 1 | Soft-start rate select |
| soft_stop_en | output | 1 | Soft-stop enable |
| pg_mode | output | 1 | Power-good mode (1 = threshold, 0 = ramp based) |
| oc_sel | output | 3 | Over-current threshold select |
| ov_sel | output | 2 | Over-voltage threshold select |
| pg_thr | output | 2 | Power-good threshold select |
| ot_sel | output | 2 | Over-temperature threshold select |
| bus_vsel | output | 1 | Bus voltage range select |
| soft_dis | output | 1 | Soft-disable bit |

## Verification
Address matching is swept over every strap value, with eight neighbouring addresses tried for each. Each strap is also changed after capture, which separates an offset latched once from one that tracks the strap, and an off-by-one in the adder from a correct match. Every pointer from 0x10 to 0x1F is first read for its default and then written and read back with all-ones and with 0x5A. The expected values come from the masks, which tells a stored bit from a masked one and a mapped pointer from an unmapped one. The ports are compared against the same pattern to catch mis-routed fields. Moving and then restoring the base register, and probing while `init_done` is low, cover the address change and the silent period.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int NREG   = 10;

  // register slot indices
  localparam int IX_BASE = 0;
  localparam int IX_VHI  = 1;
  localparam int IX_VLO  = 2;
  localparam int IX_SS   = 3;
  localparam int IX_OC   = 4;
  localparam int IX_OV   = 5;
  localparam int IX_PG   = 6;
  localparam int IX_OT   = 7;
  localparam int IX_BUS  = 8;
  localparam int IX_SDIS = 9;

  localparam logic [BYTE_W-1:0] REG_ADR [NREG] =
    '{8'h10, 8'h12, 8'h13, 8'h14, 8'h15, 8'h17, 8'h18, 8'h19, 8'h1A, 8'h1C};
  localparam logic [BYTE_W-1:0] REG_MSK [NREG] =
    '{8'hFF, 8'h01, 8'hFF, 8'h0D, 8'h07, 8'h03, 8'h03, 8'h03, 8'h02, 8'h08};
  localparam logic [BYTE_W-1:0] REG_RST [NREG] =
    '{8'h08, 8'h00, 8'h78, 8'h01, 8'h02, 8'h03, 8'h02, 8'h03, 8'h00, 8'h00};

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } fsm_t;
endpackage

// File: rtl/i2c_sync_det.sv
module i2c_sync_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              ready,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic              we,
  output logic [BYTE_W-1:0] wdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  fsm_t              st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      ptr    <= '0;
      we     <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[BYTE_W-1:1] == dev_addr && ready) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                st     <= ST_PACK;
              end else begin
                we     <= 1'b1;
                sda_oe <= 1'b1;
                st     <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh     <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
          ST_PACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WDAT;
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_IDLE;
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
          ST_RACK: if (scl_fall) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign wdata = sh;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import i2c_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [BYTE_W-1:0]      waddr,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic [BYTE_W-1:0]      raddr,
  output logic [BYTE_W-1:0]      rdata,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= REG_RST[i];
      else if (we && waddr == REG_ADR[i])   q <= wdata & REG_MSK[i];
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == REG_ADR[i]) rdata = regs_flat[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OFS_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [OFS_W-1:0] strap_ofs,
  input  logic             init_done,
  output logic [8:0]       vout_code,
  output logic             ss_rate,
  output logic             soft_stop_en,
  output logic             pg_mode,
  output logic [2:0]       oc_sel,
  output logic [1:0]       ov_sel,
  output logic [1:0]       pg_thr,
  output logic [1:0]       ot_sel,
  output logic             bus_vsel,
  output logic             soft_dis
);
  localparam int B = BYTE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [OFS_W-1:0] ofs_q;
  logic ofs_vld, ready, we;
  logic [ADDR_W-1:0] dev_addr;
  logic [B-1:0] ptr, wdata, rdata;
  logic [NREG*B-1:0] regs_flat;
  logic unused_parity;

  i2c_sync_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // offset strap taken once, first cycle out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      ofs_vld <= 1'b0;
    end else if (!ofs_vld) begin
      ofs_q   <= strap_ofs;
      ofs_vld <= 1'b1;
    end
  end

  assign ready    = ofs_vld & init_done;
  assign dev_addr = regs_flat[IX_BASE*B +: ADDR_W] + ADDR_W'(ofs_q);

  i2c_byte_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .ready(ready), .rdata(rdata),
    .sda_oe(sda_oe), .ptr(ptr), .we(we), .wdata(wdata)
  );

  cfg_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .regs_flat(regs_flat)
  );

  assign vout_code    = {regs_flat[IX_VHI*B], regs_flat[IX_VLO*B +: B]};
  assign ss_rate      = regs_flat[IX_SS*B + 3];
  assign soft_stop_en = regs_flat[IX_SS*B + 2];
  assign pg_mode      = regs_flat[IX_SS*B];
  assign oc_sel       = regs_flat[IX_OC*B +: 3];
  assign ov_sel       = regs_flat[IX_OV*B +: 2];
  assign pg_thr       = regs_flat[IX_PG*B +: 2];
  assign ot_sel       = regs_flat[IX_OT*B +: 2];
  assign bus_vsel     = regs_flat[IX_BUS*B + 1];
  assign soft_dis     = regs_flat[IX_SDIS*B + 3];
  assign unused_parity = ^regs_flat;
endmodule

// File: rtl/cfg_target_chk.sv
module cfg_target_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             init_done,
  input logic             ofs_vld,
  input logic [OFS_W-1:0] ofs_q,
  input logic             stop_det,
  input logic             we
);
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_drive_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> init_done);

  p_write_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> init_done && ofs_vld);

  p_offset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_vld |=> ofs_vld && $stable(ofs_q));
endmodule

bind i2c_cfg_target cfg_target_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .init_done(init_done), .ofs_vld(ofs_vld), .ofs_q(ofs_q),
  .stop_det(stop_det), .we(we)
);

// File: tb/test_i2c_cfg_target.sv
module test_i2c_cfg_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_tb = 1'b1, sda_tb = 1'b1;
  logic [1:0] strap = 2'd0;
  logic init_done = 1'b0;
  logic sda_oe;
  logic [8:0] vout_code;
  logic ss_rate, soft_stop_en, pg_mode, bus_vsel, soft_dis;
  logic [2:0] oc_sel;
  logic [1:0] ov_sel, pg_thr, ot_sel;
  wire sda_line = sda_tb & ~sda_oe;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  i2c_cfg_target i_i2c_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_ofs(strap), .init_done(init_done),
    .vout_code(vout_code), .ss_rate(ss_rate), .soft_stop_en(soft_stop_en),
    .pg_mode(pg_mode), .oc_sel(oc_sel), .ov_sel(ov_sel), .pg_thr(pg_thr),
    .ot_sel(ot_sel), .bus_vsel(bus_vsel), .soft_dis(soft_dis)
  );

  function automatic logic [7:0] mask_of(input logic [7:0] p);
    case (p)
      8'h10: return 8'hFF; 8'h12: return 8'h01; 8'h13: return 8'hFF;
      8'h14: return 8'h0D; 8'h15: return 8'h07; 8'h17: return 8'h03;
      8'h18: return 8'h03; 8'h19: return 8'h03; 8'h1A: return 8'h02;
      8'h1C: return 8'h08; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dflt_of(input logic [7:0] p);
    case (p)
      8'h10: return 8'h08; 8'h13: return 8'h78; 8'h14: return 8'h01;
      8'h15: return 8'h02; 8'h17: return 8'h03; 8'h18: return 8'h02;
      8'h19: return 8'h03; default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_tb = 1; qw(); scl_tb = 1; qw(); sda_tb = 0; qw(); scl_tb = 0; qw();
  endtask

  task automatic bus_stop();
    sda_tb = 0; qw(); scl_tb = 1; qw(); sda_tb = 1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_tb = b; qw(); scl_tb = 1; qw(); qw(); scl_tb = 0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_tb = 1; qw(); scl_tb = 1; qw(); b = sda_line; qw(); scl_tb = 0; qw();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    bus_start(); put_byte({a, 1'b0}, ack); bus_stop();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); put_byte({a, 1'b0}, k1); put_byte(p, k2); put_byte(d, k3); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); put_byte({a, 1'b0}, k1); put_byte(p, k2);
    bus_start(); put_byte({a, 1'b1}, k3); get_byte(d); put_bit(1'b1); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 0; strap = s; init_done = 0;
    repeat (5) @(posedge clk); #1;
    rst_n = 1;
    repeat (5) @(posedge clk); #1;
    strap = s ^ 2'd3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic ack, ok;
    logic [7:0] d, pat;
    logic [6:0] dev;

    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      if (s == 0) begin
        chk("R1 vout_code", 16'(vout_code), 16'h078);
        chk("R1 sel", {pg_mode, oc_sel, ov_sel, pg_thr, ot_sel}, 16'({1'b1, 3'd2, 2'd3, 2'd2, 2'd3}));
        chk("R1 sda_oe", 16'(sda_oe), 16'h0);
      end
      probe(7'(8 + s), ack);
      chk("R4 no ack before init_done", 16'(ack), 16'h0);
      init_done = 1;
      for (int a = 6; a < 14; a++) begin
        probe(7'(a), ack);
        chk($sformatf("R2 R3 strap=%0d addr=%0d", s, a), 16'(ack), 16'(a == 8 + s));
      end
    end

    do_reset(2'd1);
    init_done = 1;
    dev = 7'h09;

    for (int p = 16; p < 32; p++) begin
      rd(dev, 8'(p), d, ok);
      chk($sformatf("R1 R6 default ptr=%h", p), {7'h0, ok, d}, {8'h01, dflt_of(8'(p))});
    end

    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 8'hFF : 8'h5A;
      for (int p = 17; p < 32; p++) begin
        wr(dev, 8'(p), pat, ok);
        chk($sformatf("R7 write ack ptr=%h", p), 16'(ok), 16'h1);
        rd(dev, 8'(p), d, ok);
        chk($sformatf("R5 R8 R7 readback ptr=%h", p), {7'h0, ok, d}, {8'h01, pat & mask_of(8'(p))});
      end
      chk("R5 vout_code", 16'(vout_code), 16'({pat[0], pat}));
      chk("R5 ctl bits", 16'({ss_rate, soft_stop_en, pg_mode, bus_vsel, soft_dis}),
          16'({pat[3], pat[2], pat[0], pat[1], pat[3]}));
      chk("R5 selects", 16'({oc_sel, ov_sel, pg_thr, ot_sel}),
          16'({pat[2:0], pat[1:0], pat[1:0], pat[1:0]}));
      chk("R10 released after stop", 16'(sda_oe), 16'h0);
    end

    wr(dev, 8'h1B, 8'h00, ok);
    wr(dev, 8'h16, 8'h00, ok);
    chk("R7 unmapped write no effect", 16'({bus_vsel, soft_dis, oc_sel, ov_sel}),
        16'({pat[1], pat[3], pat[2:0], pat[1:0]}));

    wr(dev, 8'h10, 8'h30, ok);
    chk("R9 base write ack", 16'(ok), 16'h1);
    probe(7'h09, ack);
    chk("R9 old address silent", 16'(ack), 16'h0);
    probe(7'h31, ack);
    chk("R9 new address answers", 16'(ack), 16'h1);
    rd(7'h31, 8'h10, d, ok);
    chk("R9 R6 base readback", {7'h0, ok, d}, {8'h01, 8'h30});
    strap = 2'd2;
    probe(7'h32, ack);
    chk("R3 strap change ignored", 16'(ack), 16'h0);
    wr(7'h31, 8'h10, 8'h88, ok);
    probe(7'h09, ack);
    chk("R9 base bit7 ignored", 16'(ack), 16'h1);
    chk("R10 idle release", 16'(sda_oe), 16'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule